// File: doc/BRIEF.md
# USB Endpoint Buffer-Descriptor Engine

This block is the serial-engine side of a USB device's endpoint handling. It serves one transaction at a time. Every endpoint direction has a four-byte descriptor in a small descriptor RAM, which the CPU also uses. When a transaction request arrives, the engine reads the addressed descriptor and checks the ownership semaphore in the status byte. It then either answers at once (NAK, STALL) or moves payload bytes. OUT data goes from the receive byte stream into a 1 KB buffer RAM shared by all endpoints. IN data goes from that buffer RAM out onto the transmit stream. At the end of the transaction the engine writes the count and status back. It returns ownership to the CPU unless the descriptor asks the engine to keep it.

A transaction request carries the endpoint number, the direction and the data toggle of the token's PID. Descriptor bytes sit at CPU byte address ((ep*2)+dir)*4 + offset, with dir 1 = IN and dir 0 = OUT. Offset 0 is status, 1 is the low count byte, and 2/3 are the low/high bytes of the buffer start address; only the low 10 address bits select a buffer byte. The status byte bits, from bit 7 down to bit 0, are: owner (1 = engine), toggle, keep, hold-address, toggle-check, stall, count bit 9, count bit 8. The handshake result is 0 = ACK, 1 = NAK, 2 = STALL, 3 = ignore.

The engine walks through the states IDLE → FETCH, and then to one of RECV, DRAIN, SEND or WBACK. From there it reaches DONE and returns to IDLE. IDLE→FETCH takes a request. FETCH→DONE answers NAK or STALL. FETCH→RECV starts an OUT packet. FETCH→DRAIN starts an OUT packet with the wrong toggle. FETCH→SEND starts an IN packet with data. FETCH→WBACK handles an empty IN packet. RECV→WBACK and DRAIN→DONE happen on end of packet. SEND→WBACK happens when the last byte is accepted. WBACK→DONE writes the descriptor back, and DONE→IDLE pulses the handshake. Requests are taken only in IDLE.

Top module: `usb_bd_engine`

## Requirements
- R1: A request whose descriptor has the owner bit (status bit 7) at 0 is answered with handshake 1 (NAK), and no descriptor byte changes.
- R2: With owner=1 and the stall bit (status bit 2) set, the handshake is 2 (STALL). No byte is transmitted and the descriptor is left as it was.
- R3: An OUT packet stores its bytes at consecutive buffer addresses from the start address. The count (status bits 1:0 and count byte) is then rewritten with the number received, the owner bit is cleared, the toggle bit (status bit 6) takes the packet's toggle, and the handshake is 0 (ACK).
- R4: With toggle-check (status bit 3) set and a packet toggle different from the toggle bit, the packet is answered with handshake 3 (ignore), and both the buffer and the descriptor are left unchanged.
- R5: OUT bytes beyond the expected count are discarded, the count written back equals the expected count, and the handshake is still ACK.
- R6: With hold-address (status bit 4) set, every byte uses the start address, so after an OUT packet that address holds the last byte and the next address is untouched.
- R7: With keep (status bit 5) set, the owner bit stays 1 after the transaction completes.
- R8: An IN transaction sends exactly the 10-bit count of bytes from the buffer, in address order. Each byte is held on tx_data until tx_ready is seen, and tx_last marks only the final byte. The handshake is ACK, the owner bit is cleared and the count is kept.
- R9: A CPU write to any byte of a descriptor whose owner bit is 1 is dropped, and cpu_bd_err is asserted in the cycle of the write. A write to a CPU-owned descriptor takes effect without an error.
- R10: When a CPU descriptor write falls in the engine's write-back cycle, the engine's write wins, the CPU write is dropped and cpu_bd_err is asserted.
- R11: After reset no handshake or transmit byte is presented, and every descriptor byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tr_valid | input | 1 | Transaction request strobe (taken in IDLE) |
| tr_ep | input | EP_W | Endpoint number |
| tr_dir | input | 1 | 1 = IN, 0 = OUT |
| tr_tgl | input | 1 | PID data toggle of the packet |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End of received packet |
| tx_ready | input | 1 | Transmitter accepts tx_data |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the IN packet |
| hs_valid | output | 1 | Handshake result strobe |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 ignore |
| cpu_bd_we | input | 1 | CPU descriptor byte write |
| cpu_bd_addr | input | BD_AW | CPU descriptor byte address |
| cpu_bd_wdata | input | 8 | CPU descriptor write data |
| cpu_bd_rdata | output | 8 | CPU descriptor read data |
| cpu_bd_err | output | 1 | CPU descriptor write was dropped |
| cpu_buf_we | input | 1 | CPU buffer write |
| cpu_buf_addr | input | BUF_AW | CPU buffer address |
| cpu_buf_wdata | input | 8 | CPU buffer write data |
| cpu_buf_rdata | output | 8 | CPU buffer read data |

## Verification
The engine's descriptor write-back and a CPU write to the descriptor RAM can land in the same cycle. To provoke this, the bench ends an OUT packet, waits until the engine is in its write-back cycle, and in exactly that cycle writes the count byte of another, CPU-owned descriptor. The outcome is judged on three points: cpu_bd_err is high during that cycle, the other descriptor still reads its old count afterwards, and the engine's transaction still completes with ACK and the correct count.

// File: rtl/usb_bd_pkg.sv
package usb_bd_pkg;

    typedef enum logic [1:0] {
        HS_ACK    = 2'd0,
        HS_NAK    = 2'd1,
        HS_STALL  = 2'd2,
        HS_IGNORE = 2'd3
    } hs_code_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_RECV, S_DRAIN, S_SEND, S_WBACK, S_DONE
    } eng_state_e;

    // status byte, bit 7 first
    typedef struct packed {
        logic       own;
        logic       tgl;
        logic       keep;
        logic       hold;
        logic       tchk;
        logic       stall;
        logic [1:0] cnt_hi;
    } bd_stat_t;

endpackage

// File: rtl/usb_bd_buf_ram.sv
module usb_bd_buf_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic [7:0]    cpu_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [7:0]    eng_wdata,
    output logic [7:0]    eng_rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (eng_we)
            mem[eng_addr] <= eng_wdata;
        else if (cpu_we)
            mem[cpu_addr] <= cpu_wdata;
    end

    assign cpu_rdata = mem[cpu_addr];
    assign eng_rdata = mem[eng_addr];
endmodule

// File: rtl/usb_bd_desc_ram.sv
module usb_bd_desc_ram #(
    parameter int NUM_DESC = 8,
    parameter int IDX_W    = $clog2(NUM_DESC),
    parameter int AW       = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    output logic             cpu_err,
    input  logic [IDX_W-1:0] eng_idx,
    output logic [31:0]      eng_desc,
    input  logic             eng_we,
    input  logic [7:0]       eng_stat,
    input  logic [7:0]       eng_cnt
);
    logic [7:0] mem [NUM_DESC*4];
    logic       cpu_locked;

    assign cpu_locked = mem[{cpu_addr[AW-1:2], 2'd0}][7];
    assign cpu_err    = cpu_we && (cpu_locked || eng_we);
    assign cpu_rdata  = mem[cpu_addr];
    assign eng_desc   = {mem[{eng_idx, 2'd3}], mem[{eng_idx, 2'd2}],
                         mem[{eng_idx, 2'd1}], mem[{eng_idx, 2'd0}]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DESC*4; i++) mem[i] <= '0;
        end else if (eng_we) begin
            mem[{eng_idx, 2'd0}] <= eng_stat;
            mem[{eng_idx, 2'd1}] <= eng_cnt;
        end else if (cpu_we && !cpu_locked) begin
            mem[cpu_addr] <= cpu_wdata;
        end
    end
endmodule

// File: rtl/usb_bd_fsm.sv
module usb_bd_fsm
    import usb_bd_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int BUF_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tr_valid,
    input  logic [IDX_W-1:0]  tr_idx,
    input  logic              tr_tgl,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eop,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic [IDX_W-1:0]  desc_idx,
    input  logic [31:0]       desc_in,
    output logic              bd_we,
    output logic [7:0]        bd_stat,
    output logic [7:0]        bd_cnt,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    eng_state_e       state_q, state_d;
    hs_code_e         hs_q, hs_d;
    logic [IDX_W-1:0] idx_q;
    logic             tgl_q;
    bd_stat_t         stat_q, fetch_stat, wb_stat;
    logic [9:0]       max_q, cnt_q, fetch_cnt, wb_cnt;
    logic [15:0]      base_q, offset;
    logic             dir_in, room, last_byte;

    assign fetch_stat = bd_stat_t'(desc_in[7:0]);
    assign fetch_cnt  = {desc_in[1:0], desc_in[15:8]};
    assign dir_in     = idx_q[0];
    assign room       = cnt_q < max_q;
    assign last_byte  = (cnt_q + 10'd1) == max_q;

    // next state
    always_comb begin
        state_d = state_q;
        hs_d    = hs_q;
        unique case (state_q)
            S_IDLE:  if (tr_valid) state_d = S_FETCH;
            S_FETCH: begin
                hs_d = HS_ACK;
                if (!fetch_stat.own) begin
                    hs_d = HS_NAK;    state_d = S_DONE;
                end else if (fetch_stat.stall) begin
                    hs_d = HS_STALL;  state_d = S_DONE;
                end else if (dir_in) begin
                    state_d = (fetch_cnt == '0) ? S_WBACK : S_SEND;
                end else if (fetch_stat.tchk && (tgl_q != fetch_stat.tgl)) begin
                    hs_d = HS_IGNORE; state_d = S_DRAIN;
                end else begin
                    state_d = S_RECV;
                end
            end
            S_RECV:  if (rx_eop) state_d = S_WBACK;
            S_DRAIN: if (rx_eop) state_d = S_DONE;
            S_SEND:  if (tx_ready && last_byte) state_d = S_WBACK;
            S_WBACK: state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hs_q    <= HS_ACK;
            idx_q   <= '0;
            tgl_q   <= 1'b0;
            stat_q  <= '0;
            max_q   <= '0;
            cnt_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            hs_q    <= hs_d;
            if (state_q == S_IDLE && tr_valid) begin
                idx_q <= tr_idx;
                tgl_q <= tr_tgl;
            end
            if (state_q == S_FETCH) begin
                stat_q <= fetch_stat;
                max_q  <= fetch_cnt;
                base_q <= desc_in[31:16];
                cnt_q  <= '0;
            end else if ((state_q == S_RECV && rx_valid && room) ||
                         (state_q == S_SEND && tx_ready)) begin
                cnt_q <= cnt_q + 10'd1;
            end
        end
    end

    // outputs
    always_comb begin
        offset         = stat_q.hold ? 16'd0 : {6'd0, cnt_q};
        buf_addr       = BUF_AW'(base_q + offset);
        buf_we         = (state_q == S_RECV) && rx_valid && room;
        buf_wdata      = rx_data;
        tx_valid       = (state_q == S_SEND);
        tx_data        = buf_rdata;
        tx_last        = tx_valid && last_byte;
        hs_valid       = (state_q == S_DONE);
        hs_code        = hs_q;
        desc_idx       = idx_q;
        wb_cnt         = dir_in ? max_q : cnt_q;
        wb_stat        = stat_q;
        wb_stat.own    = stat_q.keep;
        wb_stat.tgl    = dir_in ? stat_q.tgl : tgl_q;
        wb_stat.cnt_hi = wb_cnt[9:8];
        bd_we          = (state_q == S_WBACK);
        bd_stat        = wb_stat;
        bd_cnt         = wb_cnt[7:0];
    end
endmodule

// File: rtl/usb_bd_engine.sv
module usb_bd_engine #(
    parameter int NUM_EP    = 4,
    parameter int BUF_BYTES = 1024,
    parameter int EP_W      = $clog2(NUM_EP),
    parameter int BD_AW     = EP_W + 3,
    parameter int BUF_AW    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tr_valid,
    input  logic [EP_W-1:0]   tr_ep,
    input  logic              tr_dir,
    input  logic              tr_tgl,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eop,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    input  logic              cpu_bd_we,
    input  logic [BD_AW-1:0]  cpu_bd_addr,
    input  logic [7:0]        cpu_bd_wdata,
    output logic [7:0]        cpu_bd_rdata,
    output logic              cpu_bd_err,
    input  logic              cpu_buf_we,
    input  logic [BUF_AW-1:0] cpu_buf_addr,
    input  logic [7:0]        cpu_buf_wdata,
    output logic [7:0]        cpu_buf_rdata
);
    localparam int NUM_DESC = NUM_EP * 2;
    localparam int IDX_W    = EP_W + 1;

    logic [IDX_W-1:0]  desc_idx;
    logic [31:0]       desc_word;
    logic              eng_bd_we;
    logic [7:0]        eng_bd_stat, eng_bd_cnt;
    logic              eng_buf_we;
    logic [BUF_AW-1:0] eng_buf_addr;
    logic [7:0]        eng_buf_wdata, eng_buf_rdata;

    usb_bd_desc_ram #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .AW(BD_AW)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_bd_we), .cpu_addr(cpu_bd_addr), .cpu_wdata(cpu_bd_wdata),
        .cpu_rdata(cpu_bd_rdata), .cpu_err(cpu_bd_err),
        .eng_idx(desc_idx), .eng_desc(desc_word),
        .eng_we(eng_bd_we), .eng_stat(eng_bd_stat), .eng_cnt(eng_bd_cnt)
    );

    usb_bd_buf_ram #(.DEPTH(BUF_BYTES), .AW(BUF_AW)) u_buf (
        .clk(clk),
        .cpu_we(cpu_buf_we), .cpu_addr(cpu_buf_addr), .cpu_wdata(cpu_buf_wdata),
        .cpu_rdata(cpu_buf_rdata),
        .eng_we(eng_buf_we), .eng_addr(eng_buf_addr), .eng_wdata(eng_buf_wdata),
        .eng_rdata(eng_buf_rdata)
    );

    usb_bd_fsm #(.IDX_W(IDX_W), .BUF_AW(BUF_AW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .tr_valid(tr_valid), .tr_idx({tr_ep, tr_dir}), .tr_tgl(tr_tgl),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .desc_idx(desc_idx), .desc_in(desc_word),
        .bd_we(eng_bd_we), .bd_stat(eng_bd_stat), .bd_cnt(eng_bd_cnt),
        .buf_we(eng_buf_we), .buf_addr(eng_buf_addr), .buf_wdata(eng_buf_wdata),
        .buf_rdata(eng_buf_rdata)
    );
endmodule

// File: rtl/usb_bd_engine_chk.sv
module usb_bd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       cpu_bd_we,
    input logic       cpu_bd_err,
    input logic       bd_we
);
    AST_HS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid); // R3
    AST_NO_WB_ON_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code != 2'd0) |-> !$past(bd_we)); // R1
    AST_ACK_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'd0) |-> $past(bd_we)); // R3
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R8
    AST_TX_NOT_WITH_HS: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && hs_valid)); // R2
    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_bd_err |-> cpu_bd_we); // R9
    AST_WB_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (bd_we && cpu_bd_we) |-> cpu_bd_err); // R10
endmodule

bind usb_bd_engine usb_bd_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .hs_valid(hs_valid), .hs_code(hs_code),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .cpu_bd_we(cpu_bd_we), .cpu_bd_err(cpu_bd_err), .bd_we(eng_bd_we)
);

// File: tb/usb_bd_engine_tb_top.sv
module usb_bd_engine_tb_top;
    localparam int EP_W   = 2;
    localparam int BD_AW  = 5;
    localparam int BUF_AW = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tr_valid = 0, tr_dir = 0, tr_tgl = 0;
    logic [EP_W-1:0] tr_ep = '0;
    logic rx_valid = 0, rx_eop = 0, tx_ready = 0;
    logic [7:0] rx_data = '0;
    logic tx_valid, tx_last, hs_valid, cpu_bd_err;
    logic [7:0] tx_data, cpu_bd_rdata, cpu_buf_rdata;
    logic [1:0] hs_code;
    logic cpu_bd_we = 0, cpu_buf_we = 0;
    logic [BD_AW-1:0] cpu_bd_addr = '0;
    logic [BUF_AW-1:0] cpu_buf_addr = '0;
    logic [7:0] cpu_bd_wdata = '0, cpu_buf_wdata = '0;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    usb_bd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_ep(tr_ep), .tr_dir(tr_dir),
        .tr_tgl(tr_tgl), .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .hs_valid(hs_valid), .hs_code(hs_code), .cpu_bd_we(cpu_bd_we),
        .cpu_bd_addr(cpu_bd_addr), .cpu_bd_wdata(cpu_bd_wdata), .cpu_bd_rdata(cpu_bd_rdata),
        .cpu_bd_err(cpu_bd_err), .cpu_buf_we(cpu_buf_we), .cpu_buf_addr(cpu_buf_addr),
        .cpu_buf_wdata(cpu_buf_wdata), .cpu_buf_rdata(cpu_buf_rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bd_wr(input int ep, input int dir, input int off, input int val, output bit err);
        @(negedge clk);
        cpu_bd_we = 1; cpu_bd_addr = BD_AW'((ep*2+dir)*4+off); cpu_bd_wdata = 8'(val);
        #1 err = cpu_bd_err;
        @(negedge clk);
        cpu_bd_we = 0;
    endtask

    task automatic bd_rd(input int ep, input int dir, input int off, output int val);
        cpu_bd_addr = BD_AW'((ep*2+dir)*4+off);
        #1 val = cpu_bd_rdata;
    endtask

    task automatic buf_wr(input int a, input int d);
        @(negedge clk);
        cpu_buf_we = 1; cpu_buf_addr = BUF_AW'(a); cpu_buf_wdata = 8'(d);
        @(negedge clk);
        cpu_buf_we = 0;
    endtask

    task automatic buf_rd(input int a, output int d);
        cpu_buf_addr = BUF_AW'(a);
        #1 d = cpu_buf_rdata;
    endtask

    task automatic arm(input int ep, input int dir, input int stat, input int cnt, input int addr);
        bit e;
        bd_wr(ep, dir, 2, addr & 8'hFF, e);
        bd_wr(ep, dir, 3, (addr >> 8) & 8'hFF, e);
        bd_wr(ep, dir, 1, cnt, e);
        bd_wr(ep, dir, 0, stat, e);
    endtask

    task automatic request(input int ep, input int dir, input int tgl);
        @(negedge clk);
        tr_valid = 1; tr_ep = EP_W'(ep); tr_dir = dir[0]; tr_tgl = tgl[0];
        @(negedge clk);
        tr_valid = 0;
        @(negedge clk);
    endtask

    task automatic send_bytes(input int n, input int first);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_data = 8'(first + i);
            @(negedge clk);
        end
        rx_valid = 0;
    endtask

    task automatic end_packet();
        rx_eop = 1;
        @(negedge clk);
        rx_eop = 0;
    endtask

    task automatic wait_hs(output int code, output bit saw_tx);
        int t = 0;
        saw_tx = 0;
        while (!hs_valid && t < 2000) begin
            if (tx_valid) saw_tx = 1;
            @(negedge clk);
            t++;
        end
        code = hs_valid ? int'(hs_code) : -1;
    endtask

    task automatic t_reset();
        int v;
        chk("R11 hs_valid", int'(hs_valid), 0);
        chk("R11 tx_valid", int'(tx_valid), 0);
        bd_rd(0, 0, 0, v); chk("R11 status", v, 0);
        bd_rd(3, 1, 1, v); chk("R11 count", v, 0);
    endtask

    task automatic t_nak();
        int c, v; bit s;
        arm(0, 0, 8'h40, 8, 16'h020);
        request(0, 0, 0);
        wait_hs(c, s);
        chk("R1 handshake", c, 1);
        bd_rd(0, 0, 0, v); chk("R1 status", v, 8'h40);
        bd_rd(0, 0, 1, v); chk("R1 count", v, 8);
    endtask

    task automatic t_stall();
        int c, v; bit s;
        arm(0, 1, 8'h84, 5, 16'h030);
        request(0, 1, 0);
        wait_hs(c, s);
        chk("R2 handshake", c, 2);
        chk("R2 no tx", int'(s), 0);
        bd_rd(0, 1, 0, v); chk("R2 status", v, 8'h84);
        bd_rd(0, 1, 1, v); chk("R2 count", v, 5);
    endtask

    task automatic t_out();
        int c, v; bit s;
        arm(1, 0, 8'h80, 8, 16'h100);
        request(1, 0, 1);
        send_bytes(5, 8'h30);
        end_packet();
        wait_hs(c, s);
        chk("R3 handshake", c, 0);
        for (int i = 0; i < 5; i++) begin
            buf_rd(16'h100 + i, v); chk("R3 data", v, 8'h30 + i);
        end
        bd_rd(1, 0, 1, v); chk("R3 count", v, 5);
        bd_rd(1, 0, 0, v); chk("R3 status", v, 8'h40);
    endtask

    task automatic t_toggle();
        int c, v; bit s;
        for (int i = 0; i < 3; i++) buf_wr(16'h300 + i, 8'hEE);
        arm(1, 0, 8'h88, 4, 16'h300);
        request(1, 0, 1);
        send_bytes(3, 8'h50);
        end_packet();
        wait_hs(c, s);
        chk("R4 handshake", c, 3);
        for (int i = 0; i < 3; i++) begin
            buf_rd(16'h300 + i, v); chk("R4 buffer", v, 8'hEE);
        end
        bd_rd(1, 0, 0, v); chk("R4 status", v, 8'h88);
        bd_rd(1, 0, 1, v); chk("R4 count", v, 4);
    endtask

    task automatic t_overflow();
        int c, v; bit s;
        buf_wr(16'h043, 8'h11);
        arm(2, 0, 8'h80, 3, 16'h040);
        request(2, 0, 0);
        send_bytes(6, 8'h60);
        end_packet();
        wait_hs(c, s);
        chk("R5 handshake", c, 0);
        bd_rd(2, 0, 1, v); chk("R5 count", v, 3);
        buf_rd(16'h042, v); chk("R5 last kept", v, 8'h62);
        buf_rd(16'h043, v); chk("R5 extra dropped", v, 8'h11);
    endtask

    task automatic t_hold();
        int c, v; bit s;
        buf_wr(16'h081, 8'h22);
        arm(3, 0, 8'h90, 4, 16'h080);
        request(3, 0, 0);
        send_bytes(4, 8'hA0);
        end_packet();
        wait_hs(c, s);
        chk("R6 handshake", c, 0);
        buf_rd(16'h080, v); chk("R6 same address", v, 8'hA3);
        buf_rd(16'h081, v); chk("R6 next untouched", v, 8'h22);
    endtask

    task automatic in_run(input int ep, input int n, input int addr, input int stat_hi,
                          output int code);
        int got = 0, bad = 0, lastbad = 0, t = 0;
        for (int i = 0; i < n; i++) buf_wr(addr + i, i*7 + 3);
        arm(ep, 1, stat_hi | ((n >> 8) & 3), n & 8'hFF, addr);
        request(ep, 1, 0);
        while (t < 5000) begin
            tx_ready = (t % 3) != 2;
            #1;
            if (hs_valid) break;
            if (tx_valid && tx_ready) begin
                if (tx_data != 8'(got*7 + 3)) bad++;
                if (tx_last != (got == n-1)) lastbad++;
                got++;
            end
            @(negedge clk);
            t++;
        end
        tx_ready = 0;
        code = hs_valid ? int'(hs_code) : -1;
        chk("R8 byte count", got, n);
        chk("R8 data", bad, 0);
        chk("R8 last marker", lastbad, 0);
    endtask

    task automatic t_in();
        int c, v;
        in_run(1, 260, 16'h200, 8'h80, c);
        chk("R8 handshake", c, 0);
        bd_rd(1, 1, 0, v); chk("R8 status", v, 8'h01);
        bd_rd(1, 1, 1, v); chk("R8 count", v, 8'h04);
    endtask

    task automatic t_keep();
        int c, v; bit e;
        in_run(2, 2, 16'h010, 8'hA0, c);
        chk("R7 handshake", c, 0);
        bd_rd(2, 1, 0, v); chk("R7 owner kept", v, 8'hA0);
        bd_wr(2, 1, 1, 8'h77, e);
        chk("R9 error flag", int'(e), 1);
        bd_rd(2, 1, 1, v); chk("R9 write dropped", v, 2);
        bd_wr(3, 1, 1, 8'h66, e);
        chk("R9 free write no error", int'(e), 0);
        bd_rd(3, 1, 1, v); chk("R9 free write lands", v, 8'h66);
    endtask

    task automatic t_collide();
        int v; bit e;
        bd_wr(2, 0, 1, 8'h09, e);
        arm(1, 0, 8'h80, 8, 16'h180);
        request(1, 0, 0);
        send_bytes(2, 8'h70);
        end_packet();
        // engine is in write-back now
        cpu_bd_we = 1; cpu_bd_addr = BD_AW'((2*2+0)*4+1); cpu_bd_wdata = 8'h55;
        #1 chk("R10 error flag", int'(cpu_bd_err), 1);
        @(negedge clk);
        cpu_bd_we = 0;
        chk("R10 handshake valid", int'(hs_valid), 1);
        chk("R10 handshake ACK", int'(hs_code), 0);
        bd_rd(2, 0, 1, v); chk("R10 cpu write dropped", v, 8'h09);
        bd_rd(1, 0, 1, v); chk("R10 engine count", v, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_nak();
        t_stall();
        t_out();
        t_toggle();
        t_overflow();
        t_hold();
        t_in();
        t_keep();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule